// File: doc/BRIEF.md
# Recently-Used-Bit Replacement Unit

This unit holds the replacement state of an N-way set-associative cache and names the way to evict when the cache controller asks for one. Each set keeps one "used" bit per way. Every access (hit or fill) reported on the access port sets the bit of the touched way. A set never reaches the point where every bit is 1: the access that would fill the last zero bit keeps only the accessed way marked and clears the others.

A policy input selects how victims are picked. In used-bit policy the victim comes from the ways whose bit is 0. In the not-most-recently-used policy only one small index per set is consulted, the way touched last, and any other way may be evicted. Both kinds of state are updated on every access whatever the policy, so the policy input can change at any cycle. The choice among eligible ways is pseudo-random: a free-running 16-bit LFSR gives a starting way, and the first eligible way found from there in ascending, wrapping order is returned. The victim output is combinational from the state at the start of the cycle, so a victim request and an access to the same set in one cycle see the state before that access.

Top module: `mru_repl_unit`

## Requirements
- R1: After reset every used bit of every set is 0 and every set's recorded most-recent way is way 0.
- R2: An access with `acc_valid` high sets the used bit of (`acc_set`, `acc_way`) at the next clock edge, and leaves every other set unchanged.
- R3: With `nmru_mode` = 0 and `vic_req` = 1, `vic_way` is always a way whose used bit in `vic_set` is 0; when exactly one bit is 0, it is that way.
- R4: When an access would make all used bits of its set 1, after that edge only the accessed way's bit is 1 and all other bits of that set are 0.
- R5: With `nmru_mode` = 1 and `vic_req` = 1, `vic_way` differs from the way most recently accessed in `vic_set` (way 0 if the set was not accessed since reset).
- R6: Used bits and most-recent indices are updated on every access in either policy, so a policy change takes effect on the very next request with up-to-date state.
- R7: A victim request and an access to the same set in the same cycle return a victim computed from the state before that access.
- R8: The victim choice is pseudo-random: a set with two eligible ways returns each of them over repeated requests.
- R9: When `vic_req` is 0, `vic_way` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| nmru_mode | input | 1 | 0: used-bit policy, 1: not-most-recently-used policy |
| acc_valid | input | 1 | An access to report this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way index of the access |
| vic_req | input | 1 | Victim requested this cycle |
| vic_set | input | SET_W | Set for which a victim is requested |
| vic_way | output | WAY_W | Way to evict (combinational) |

## Verification
The bench builds the unit with 4 ways and 8 sets, so a handful of accesses fills a set and the clear-on-full step, single-eligible-way cases and the same-cycle overlap of access and request are all reached within a few cycles. With 8 sets, random traffic revisits each set often and reaches every fill level of the used bits, while switching policy at random exercises both state kinds against a bench model. Single-eligible cases give exact expected ways independent of the LFSR.

// File: rtl/repl_pkg.sv
// Shared types for the replacement unit.
package repl_pkg;
    typedef enum logic {
        POL_USEDBIT = 1'b0,
        POL_NMRU    = 1'b1
    } repl_policy_e;
endpackage

// File: rtl/repl_lfsr16.sv
// Free-running 16-bit Fibonacci LFSR (taps 16,14,13,11).
// Assumes: nothing; it never reaches the all-zero state.
module repl_lfsr16 (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] value
);
    localparam logic [15:0] SEED = 16'hACE1;

    logic fb;
    assign fb = value[15] ^ value[13] ^ value[12] ^ value[10];

    // Advance one step every cycle; reload seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= SEED;
        else        value <= {value[14:0], fb};
    end

    assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
        value != 16'h0000);
endmodule

// File: rtl/repl_state.sv
// Per-set used bits and most-recent way index, with one update port and one
// read port. Assumes WAYS >= 2. The read port shows the state before any
// update in the same cycle.
module repl_state #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [SET_W-1:0] upd_set,
    input  logic [WAY_W-1:0] upd_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAYS-1:0]  rd_used,
    output logic [WAY_W-1:0] rd_mru
);
    logic [WAYS-1:0]  used_q [SETS];
    logic [WAY_W-1:0] mru_q  [SETS];
    logic [WAYS-1:0]  hit_mask;
    logic [WAYS-1:0]  merged;
    logic [WAYS-1:0]  used_nxt;

    // Compute the new used bits of the accessed set, clearing on full.
    always_comb begin
        hit_mask = '0;
        hit_mask[upd_way] = 1'b1;
        merged   = used_q[upd_set] | hit_mask;
        used_nxt = (&merged) ? hit_mask : merged;
    end

    // Store used bits and most-recent index; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                used_q[s] <= '0;
                mru_q[s]  <= '0;
            end
        end else if (upd_en) begin
            used_q[upd_set] <= used_nxt;
            mru_q[upd_set]  <= upd_way;
        end
    end

    assign rd_used = used_q[rd_set];
    assign rd_mru  = mru_q[rd_set];

    assert_access_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> used_q[$past(upd_set)][$past(upd_way)]);
    assert_full_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (&(used_q[upd_set] | (WAYS'(1) << upd_way))))
        |=> ($countones(used_q[$past(upd_set)]) == 1));
    assert_never_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> !(&used_q[$past(upd_set)]));
    assert_mru_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (mru_q[$past(upd_set)] == $past(upd_way)));
endmodule

// File: rtl/repl_pick.sv
// Round-robin search for the first eligible way at or after a start index,
// wrapping. Assumes WAYS is a power of two and at least one way is eligible.
module repl_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  eligible,
    input  logic [WAY_W-1:0] start,
    output logic [WAY_W-1:0] pick
);
    logic [WAY_W-1:0] idx;

    // Scan offsets downwards so the smallest eligible offset wins.
    always_comb begin
        pick = start;
        idx  = start;
        for (int k = WAYS - 1; k >= 0; k--) begin
            idx = start + WAY_W'(k);
            if (eligible[idx]) pick = idx;
        end
    end
endmodule

// File: rtl/mru_repl_unit.sv
// Replacement unit top: used-bit state per set, NMRU index per set, LFSR
// start point and round-robin victim pick. Assumes WAYS is a power of two,
// WAYS >= 2 and SETS >= 2.
module mru_repl_unit #(
    parameter int WAYS = 4,
    parameter int SETS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmru_mode,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [WAY_W-1:0] acc_way,
    input  logic             vic_req,
    input  logic [SET_W-1:0] vic_set,
    output logic [WAY_W-1:0] vic_way
);
    import repl_pkg::*;

    repl_policy_e     policy;
    logic [15:0]      rnd;
    logic [WAYS-1:0]  cur_used;
    logic [WAY_W-1:0] cur_mru;
    logic [WAYS-1:0]  elig;
    logic [WAY_W-1:0] chosen;

    assign policy = repl_policy_e'(nmru_mode);

    repl_lfsr16 lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    repl_state #(.WAYS(WAYS), .SETS(SETS)) state_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (acc_valid),
        .upd_set (acc_set),
        .upd_way (acc_way),
        .rd_set  (vic_set),
        .rd_used (cur_used),
        .rd_mru  (cur_mru)
    );

    // Build the eligible-way mask for the selected policy.
    always_comb begin
        if (policy == POL_NMRU) begin
            elig = '1;
            elig[cur_mru] = 1'b0;
        end else begin
            elig = ~cur_used;
        end
    end

    repl_pick #(.WAYS(WAYS)) pick_i (
        .eligible (elig),
        .start    (rnd[WAY_W-1:0]),
        .pick     (chosen)
    );

    assign vic_way = vic_req ? chosen : '0;

    assert_victim_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && !nmru_mode) |-> !cur_used[vic_way]);
    assert_victim_not_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vic_req && nmru_mode) |-> (vic_way != cur_mru));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vic_req |-> (vic_way == '0));
endmodule

// File: tb/mru_repl_unit_tb_top.sv
// Bench: directed corner cases plus seeded random traffic against a model.
module mru_repl_unit_tb_top;
    localparam int WAYS = 4;
    localparam int SETS = 8;
    localparam int WW = $clog2(WAYS);
    localparam int SW = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmru_mode = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [WW-1:0] acc_way = '0;
    logic          vic_req = 1'b0;
    logic [SW-1:0] vic_set = '0;
    logic [WW-1:0] vic_way;

    int n_chk = 0;
    int n_bad = 0;
    logic [WAYS-1:0] m_used [SETS];
    logic [WW-1:0]   m_mru  [SETS];
    logic            seen [WAYS];

    always #5 clk = ~clk;

    mru_repl_unit #(.WAYS(WAYS), .SETS(SETS)) dut_i (
        .clk(clk), .rst_n(rst_n), .nmru_mode(nmru_mode),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
        .vic_req(vic_req), .vic_set(vic_set), .vic_way(vic_way)
    );

    function automatic logic [WAYS-1:0] elig_of(input logic [SW-1:0] s, input logic m);
        logic [WAYS-1:0] e;
        if (m) begin e = '1; e[m_mru[s]] = 1'b0; end
        else e = ~m_used[s];
        return e;
    endfunction

    function automatic int only_way(input logic [WAYS-1:0] e);
        for (int w = 0; w < WAYS; w++) if (e[w]) return w;
        return 0;
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check victim before the edge, update model.
    task automatic step(input logic av, input int as, input int aw,
                        input logic vr, input int vs, input logic md, input string req);
        logic [WAYS-1:0] e;
        logic [WAYS-1:0] mg;
        @(negedge clk);
        acc_valid = av; acc_set = SW'(as); acc_way = WW'(aw);
        vic_req = vr; vic_set = SW'(vs); nmru_mode = md;
        #2;
        if (vr) begin
            e = elig_of(SW'(vs), md);
            if ($countones(e) == 1)
                check(req, vic_way == WW'(only_way(e)), vic_way, only_way(e));
            else
                check(req, e[vic_way], vic_way, -1);
            seen[vic_way] = 1'b1;
        end else begin
            check({req, " R9"}, vic_way == '0, vic_way, 0);
        end
        @(posedge clk);
        if (av) begin
            mg = m_used[as] | (WAYS'(1) << aw);
            m_used[as] = (&mg) ? (WAYS'(1) << aw) : mg;
            m_mru[as] = WW'(aw);
        end
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin m_used[s] = '0; m_mru[s] = '0; end
        for (int w = 0; w < WAYS; w++) seen[w] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R5: after reset NMRU never picks way 0.
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 1, "R1 R5 reset mru");
        // R1 / R2 / R3: three accesses leave exactly way 3 free.
        step(1, 5, 0, 0, 0, 0, "R2");
        step(1, 5, 1, 0, 0, 0, "R2");
        step(1, 5, 2, 1, 5, 0, "R2 R3 partial");
        step(0, 0, 0, 1, 5, 0, "R1 R3 single free");
        // R7: same-cycle access to way 3 and request: pre-update victim 3.
        step(1, 5, 3, 1, 5, 0, "R7 same cycle");
        // R4: only way 3 remains set; then 0,1 set -> victim must be 2.
        step(0, 0, 0, 1, 5, 0, "R4 after clear");
        step(1, 5, 0, 0, 0, 0, "R4");
        step(1, 5, 1, 1, 5, 0, "R4 partial");
        step(0, 0, 0, 1, 5, 0, "R4 exact");
        // R2: set 6 unaffected by set 5 traffic.
        step(1, 6, 1, 0, 0, 0, "R2");
        step(1, 6, 2, 0, 0, 0, "R2");
        step(1, 6, 3, 0, 0, 0, "R2");
        step(0, 0, 0, 1, 6, 0, "R2 other set");
        // R6: access in used-bit mode, then NMRU sees the new most-recent way.
        step(1, 7, 2, 0, 0, 0, "R6");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 7, 1, "R6 R5 switch");
        // R8: two free ways both chosen over time.
        for (int w = 0; w < WAYS; w++) seen[w] = 1'b0;
        step(1, 3, 0, 0, 0, 0, "R8");
        step(1, 3, 1, 0, 0, 0, "R8");
        for (int i = 0; i < 40; i++) step(0, 0, 0, 1, 3, 0, "R8 R3");
        check("R8 spread", seen[2] && seen[3], int'(seen[2]) + int'(seen[3]), 2);

        // Random traffic, fixed seed.
        void'($urandom(1234));
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, SETS - 1)),
                 int'($urandom_range(0, WAYS - 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, SETS - 1)), 1'($urandom_range(0, 1)),
                 "R3 R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule